// File: doc/BRIEF.md
# Serial Segment Word Loader

This block takes segment data that arrives one bit at a time and turns it into a 38-bit parallel word that holds still for a display driver. A host drives a data line, a serial clock, an active-low select and a load strobe. A 38-stage shift register collects the data. A level-transparent holding register then passes the collected word to the segment outputs. The holding register is open while the strobe is high and the select is low. It keeps its value once the strobe drops.

Three tap outputs bring out stages 30, 32 and 38 of the shift register. The taps are retimed to the rising clock edge, half a serial period after the shift that fed them. This lets the next loader in a chain take its data from any one of them, so chains of 30, 32 or 38 segments per device can be built.

All pins are sampled by a fast system clock through a two-flop synchronizer, and the serial clock edges are found in that domain. The system clock must run at least four times as fast as the serial clock. A mode pin picks how the clock and the select are combined:
- **Gated scheme**: the shift clock is the serial clock forced high while the select is high.
- **Enable scheme**: the select is sampled as an enable at each serial clock edge.

Top module: `seg_loader`

## Requirements
- R1: After reset, all 38 bits of `seg_word` and all three taps read 0.
- R2: Each falling shift-clock edge moves every stage up by one and puts `ser_dat` into stage 1 (`seg_word[0]`). After 38 shifts, the first bit sent sits in stage 38 (`seg_word[37]`).
- R3: Serial clock edges that occur while `ser_sel_n` is high change neither the shift register nor the taps.
- R4: While `ser_load` is high and `ser_sel_n` is low, `seg_word` follows the shift register. Once `ser_load` is low, `seg_word` holds.
- R5: A load pulse given while `ser_sel_n` is high leaves `seg_word` unchanged.
- R6: The taps `tap_a`, `tap_b` and `tap_c` show stages 30, 32 and 38, which are `seg_word` bit positions 29, 31 and 37. They update only on a rising shift-clock edge, so they do not change between a falling edge and the next rising edge.
- R7: In the gated scheme (`mode_legacy` = 1):
  - A fall of `ser_sel_n` while `ser_clk` is low is a falling shift edge and shifts once.
  - A rise of `ser_sel_n` while `ser_clk` is low is a rising edge and updates the taps.
- R8: In the enable scheme (`mode_legacy` = 0), a change of `ser_sel_n` alone never shifts and never updates the taps.
- R9: A burst sent with `ser_sel_n` held low gives the same word and the same taps in both schemes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_legacy | input | 1 | 1 selects the gated scheme, 0 selects the enable scheme |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial clock; data shifts on its falling edge |
| ser_sel_n | input | 1 | Active-low select |
| ser_load | input | 1 | Load strobe; the holding register is open while it is high |
| seg_word | output | 38 | Held segment word; bit 0 is stage 1 |
| tap_a | output | 1 | Retimed stage 30 |
| tap_b | output | 1 | Retimed stage 32 |
| tap_c | output | 1 | Retimed stage 38 |

## Verification
The bench builds the loader with its default values: 38 stages, taps at 30 and 32, and a synchronizer depth of 2. With these values a full burst fills the word exactly, and every tap can be compared against a known bit position of the sent pattern. The depth of 2 is the shortest path from pin to output. Each serial step is held for six system clocks, which covers that path plus the holding register, so the model can be compared once the outputs have settled. Both schemes are run with the same pattern, and select edges are also driven while the serial clock is low. This exposes the one place where the two schemes are meant to differ.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

  // Synchronized pin bundle, packed in a fixed order.
  typedef struct packed {
    logic mode;
    logic ld;
    logic sel_n;
    logic sck;
    logic dat;
  } pin_bundle_t;

  localparam int unsigned PIN_W = $bits(pin_bundle_t);

  // Idle levels: clock high, select deasserted, load low, gated scheme.
  localparam pin_bundle_t PIN_IDLE = '{mode: 1'b1, ld: 1'b0, sel_n: 1'b1, sck: 1'b1, dat: 1'b0};

  // Shift clock as seen by the shift register in each scheme.
  function automatic logic eff_clock(input logic legacy, input logic sck, input logic sel_n);
    return legacy ? (sck | sel_n) : sck;
  endfunction

  // Stage numbers start at 1; vector indices start at 0.
  function automatic int unsigned stage_to_index(input int unsigned stage);
    return stage - 1;
  endfunction

endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_async;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign d_sync = pipe[LAST];
endmodule

// File: rtl/sl_strobe.sv
module sl_strobe
  import seg_loader_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic legacy,
  input  logic sck,
  input  logic sel_n,
  output logic shift_ev,
  output logic retime_ev
);
  logic eff_q;
  logic eff_now;
  logic fall_raw;
  logic rise_raw;

  assign eff_now  = eff_clock(legacy, sck, sel_n);
  assign fall_raw = eff_q & ~eff_now;
  assign rise_raw = ~eff_q & eff_now;

  // In the gated scheme, a rise caused by the select counts as an edge.
  assign shift_ev  = fall_raw & ~sel_n;
  assign retime_ev = rise_raw & (legacy | ~sel_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= 1'b1;
    else        eff_q <= eff_now;
  end

  // R6
  edges_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_ev && retime_ev));

  // R7
  shift_needs_prior_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |-> $past(eff_now));
endmodule

// File: rtl/sl_chain.sv
module sl_chain
  import seg_loader_pkg::*;
#(
  parameter int unsigned STAGES = 38,
  parameter int unsigned TAP_A = 30,
  parameter int unsigned TAP_B = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_ev,
  input  logic              retime_ev,
  input  logic              din,
  output logic [STAGES-1:0] stages,
  output logic [2:0]        taps
);
  localparam int unsigned NTAP = 3;
  localparam int unsigned TAP_STAGE [NTAP] = '{TAP_A, TAP_B, STAGES};

  logic [STAGES-1:0] sr_q;
  logic [NTAP-1:0]   tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_ev) sr_q <= {sr_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
    end else if (retime_ev) begin
      for (int t = 0; t < NTAP; t++) tap_q[t] <= sr_q[stage_to_index(TAP_STAGE[t])];
    end
  end

  assign stages = sr_q;
  assign taps   = tap_q;

  // R6
  tap_last_retime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retime_ev |=> taps[2] == $past(stages[STAGES-1]));

  // R6
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retime_ev |=> $stable(taps));

  // R2
  shift_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ev |=> $stable(stages));
endmodule

// File: rtl/sl_latch.sv
module sl_latch #(
  parameter int unsigned W = 38
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (open_en) q <= d;
  end

  // R4
  latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |=> q == $past(d));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_en |=> $stable(q));
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_loader_pkg::*;
#(
  parameter int unsigned SEG_COUNT = 38,
  parameter int unsigned TAP_A_STAGE = 30,
  parameter int unsigned TAP_B_STAGE = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_legacy,
  input  logic                 ser_dat,
  input  logic                 ser_clk,
  input  logic                 ser_sel_n,
  input  logic                 ser_load,
  output logic [SEG_COUNT-1:0] seg_word,
  output logic                 tap_a,
  output logic                 tap_b,
  output logic                 tap_c
);
  pin_bundle_t pins_raw;
  pin_bundle_t pins_s;
  logic [PIN_W-1:0] pins_s_vec;

  logic shift_ev;
  logic retime_ev;
  logic open_en;
  logic [SEG_COUNT-1:0] stages;
  logic [2:0] taps;

  assign pins_raw = '{mode: mode_legacy, ld: ser_load, sel_n: ser_sel_n, sck: ser_clk, dat: ser_dat};

  sl_sync #(.W(PIN_W), .DEPTH(SYNC_DEPTH), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pins_raw), .d_sync(pins_s_vec)
  );
  assign pins_s = pin_bundle_t'(pins_s_vec);

  sl_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .legacy(pins_s.mode), .sck(pins_s.sck),
    .sel_n(pins_s.sel_n), .shift_ev(shift_ev), .retime_ev(retime_ev)
  );

  sl_chain #(.STAGES(SEG_COUNT), .TAP_A(TAP_A_STAGE), .TAP_B(TAP_B_STAGE)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_ev(shift_ev), .retime_ev(retime_ev),
    .din(pins_s.dat), .stages(stages), .taps(taps)
  );

  assign open_en = pins_s.ld & ~pins_s.sel_n;

  sl_latch #(.W(SEG_COUNT)) u_latch (
    .clk(clk), .rst_n(rst_n), .open_en(open_en), .d(stages), .q(seg_word)
  );

  assign tap_a = taps[0];
  assign tap_b = taps[1];
  assign tap_c = taps[2];

  // R3
  sel_blocks_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s.sel_n |-> !shift_ev);

  // R5
  sel_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s.sel_n |=> $stable(seg_word));

  // R8
  enable_scheme_sel_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_s.mode && $stable(pins_s.sck)) |-> !(shift_ev || retime_ev));
endmodule

// File: tb/seg_loader_test.sv
module seg_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_m = 1'b1, p_d = 1'b0, p_c = 1'b1, p_s = 1'b1, p_l = 1'b0;
  logic [37:0] seg_word;
  logic tap_a, tap_b, tap_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [37:0] m_sr = '0;
  logic [37:0] m_lat = '0;
  logic [2:0]  m_taps = '0;

  localparam logic [37:0] PAT = 38'h2B_C5A3_9E71;

  always #5 clk = ~clk;

  seg_loader uut (
    .clk(clk), .rst_n(rst_n), .mode_legacy(p_m), .ser_dat(p_d), .ser_clk(p_c),
    .ser_sel_n(p_s), .ser_load(p_l), .seg_word(seg_word),
    .tap_a(tap_a), .tap_b(tap_b), .tap_c(tap_c)
  );

  task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One serial step: apply the pin levels, update the model, let the outputs settle, compare.
  task automatic step(input string req, input logic d, input logic c, input logic s, input logic l);
    logic eo, en;
    eo = p_m ? (p_c | p_s) : p_c;
    en = p_m ? (c | s) : c;
    if (eo && !en && !s) m_sr = {m_sr[36:0], d};
    if (!eo && en && (p_m || !s)) m_taps = {m_sr[37], m_sr[31], m_sr[29]};
    if (l && !s) m_lat = m_sr;
    p_d = d; p_c = c; p_s = s; p_l = l;
    repeat (6) @(posedge clk);
    #2;
    check(req, {seg_word, tap_c, tap_b, tap_a}, {m_lat, m_taps});
  endtask

  task automatic send_bit(input string req, input logic b, input logic l);
    step(req, b, 1'b1, 1'b0, l);
    step(req, b, 1'b0, 1'b0, l);
    step(req, b, 1'b1, 1'b0, l);
  endtask

  task automatic burst(input string req, input logic [37:0] v);
    for (int i = 37; i >= 0; i--) send_bit(req, v[i], 1'b0);
  endtask

  task automatic load_pulse(input string req);
    step(req, p_d, 1'b1, 1'b0, 1'b0);
    step(req, p_d, 1'b1, 1'b0, 1'b1);
    step(req, p_d, 1'b1, 1'b0, 1'b0);
    step(req, p_d, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [37:0] held;
    logic [2:0] tsnap;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", {seg_word, tap_c, tap_b, tap_a}, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1 after release", {seg_word, tap_c, tap_b, tap_a}, '0);

    // R2: gated scheme, full burst, then load
    burst("R2", PAT);
    load_pulse("R2");
    check("R2 word order", {3'b0, seg_word}, {3'b0, PAT});
    // R6: taps hold stages 30, 32, 38
    check("R6 tap bits", {38'b0, tap_c, tap_b, tap_a}, {38'b0, PAT[37], PAT[31], PAT[29]});

    // R3: clock pulses with select high are ignored
    for (int i = 0; i < 4; i++) begin
      step("R3", 1'b1, 1'b0, 1'b1, 1'b0);
      step("R3", 1'b1, 1'b1, 1'b1, 1'b0);
    end
    load_pulse("R3");
    check("R3 no shift", {3'b0, seg_word}, {3'b0, PAT});

    // R5: load with select high has no effect
    for (int i = 0; i < 5; i++) send_bit("R5", 1'b1, 1'b0);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b1);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0);
    check("R5 load ignored", {3'b0, seg_word}, {3'b0, PAT});
    load_pulse("R5");
    check("R5 load taken", {3'b0, seg_word}, {3'b0, {PAT[32:0], 5'b11111}});

    // R4: transparent while load is high
    held = seg_word;
    send_bit("R4", 1'b0, 1'b1);
    check("R4 follows", {3'b0, seg_word}, {3'b0, {held[36:0], 1'b0}});
    held = seg_word;
    step("R4", 1'b1, 1'b1, 1'b0, 1'b0);
    send_bit("R4", 1'b1, 1'b0);
    check("R4 holds", {3'b0, seg_word}, {3'b0, held});

    // R6: taps do not move between falling and rising edges
    tsnap = {tap_c, tap_b, tap_a};
    step("R6", 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 hold before rise", {38'b0, tap_c, tap_b, tap_a}, {38'b0, tsnap});
    step("R6", 1'b0, 1'b1, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b1, 1'b1, 1'b0);

    // R7: gated scheme, select edges with the clock low
    load_pulse("R7");
    held = seg_word;
    step("R7", 1'b1, 1'b0, 1'b1, 1'b0);
    step("R7", 1'b1, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 1'b0, 1'b1, 1'b0);
    step("R7", 1'b1, 1'b1, 1'b1, 1'b0);
    load_pulse("R7");
    check("R7 select edge shifts", {3'b0, seg_word}, {3'b0, {held[36:0], 1'b1}});

    // R8: enable scheme, select edges alone do nothing
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0);
    p_m = 1'b0;
    repeat (6) @(posedge clk);
    held = seg_word;
    tsnap = {tap_c, tap_b, tap_a};
    step("R8", 1'b1, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b0, 1'b0, 1'b0);
    step("R8", 1'b1, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b1, 1'b1, 1'b0);
    check("R8 taps unmoved", {38'b0, tap_c, tap_b, tap_a}, {38'b0, tsnap});
    load_pulse("R8");
    check("R8 no shift", {3'b0, seg_word}, {3'b0, held});

    // R9: same burst in the enable scheme gives the same result
    burst("R9", PAT);
    load_pulse("R9");
    check("R9 word", {3'b0, seg_word}, {3'b0, PAT});
    check("R9 taps", {38'b0, tap_c, tap_b, tap_a}, {38'b0, PAT[37], PAT[31], PAT[29]});
    burst("R9", ~PAT);
    load_pulse("R9");
    check("R9 inverse word", {3'b0, seg_word}, {3'b0, ~PAT});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule